// File: doc/BRIEF.md
# Stereo Sample Buffer with DMA Request Steering

This block sits between a sample source and a synthesis engine that consumes audio words. Each of its two channels, left and right, holds a fixed number of bits of sample data (1024 by default) arranged as words. Words arrive either from a host write strobe or from a DMA engine that writes using a write strobe gated by an acknowledge. The engine drains each channel through a simple pop port. In mono operation only the left channel is used. In stereo operation a channel-select input steers host writes to one side or the other, and each side has its own DMA request and acknowledge pair.

Every channel drives an empty flag, a more-than-half flag and a full flag. All three share one programmable polarity. A play-active output rises once every channel in use has filled beyond half, which gives the consumer its start point. It falls when those channels have drained to empty. A DMA request rises when its channel runs dry and is held until that channel fills completely.

Top module: `stereo_sample_fifo`

## Requirements
- R1: Each channel stores DEPTH = CAP_BITS / DATA_W words (64 by default). A channel accepts exactly DEPTH writes from empty before it reports full.
- R2: empty_flag[c] is active whenever channel c (index 0 = left, 1 = right) holds zero words.
- R3: half_flag[c] is active whenever channel c holds more than DEPTH/2 words, which is 33 or more by default.
- R4: full_flag[c] is active when channel c holds DEPTH words. While it is full, a write to that channel is discarded and the stored words are unchanged.
- R5: With cfg_flag_low = 0 the three flags are high when active. With cfg_flag_low = 1 all three are driven low when active.
- R6: In stereo mode (cfg_stereo = 1) a host write goes to the right channel when host_ch = 1 and to the left channel when host_ch = 0. In mono mode every write goes to the left channel, whatever the value of host_ch.
- R7: A pop on a non-empty channel places that channel's oldest word on its rd_data output at the next clock edge, and rd_data then holds it until the next pop. A pop on an empty channel drives rd_data to 0 and pulses that channel's underrun output high for one cycle.
- R8: play_active rises one cycle after every channel in use (left only in mono, both in stereo) holds more than DEPTH/2 words. It falls one cycle after every channel in use is empty.
- R9: With cfg_dma_en = 1, a channel's request (dma_req_l, or dma_req_r in stereo mode only) goes high at the edge where that channel's count becomes 0. It stays high until the edge where the count reaches DEPTH. A request is low whenever its channel's DMA is not enabled.
- R10: With cfg_dma_en = 1, a cycle with dma_wr_n = 0 writes wr_data into the channel whose acknowledge is active. An acknowledge is active low when cfg_ack_high = 0 and active high when cfg_ack_high = 1. In mono mode only dma_ack_l is used. In stereo mode, if both acknowledges are active, the left channel takes the write.
- R11: With cfg_dma_en = 1, host_wr has no effect. With cfg_dma_en = 0, dma_wr_n has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_stereo | input | 1 | 1 = two channels, 0 = left channel only |
| cfg_dma_en | input | 1 | 1 = writes come from the DMA strobe, 0 = from host_wr |
| cfg_flag_low | input | 1 | 1 = status flags active low |
| cfg_ack_high | input | 1 | 1 = DMA acknowledges active high |
| host_wr | input | 1 | Host write, one word per cycle held high |
| host_ch | input | 1 | Stereo channel select for host writes, 1 = right |
| wr_data | input | DATA_W | Write word for both sources |
| dma_wr_n | input | 1 | DMA write strobe, active low |
| dma_ack_l | input | 1 | Left DMA acknowledge |
| dma_ack_r | input | 1 | Right DMA acknowledge |
| dma_req_l | output | 1 | Left DMA request |
| dma_req_r | output | 1 | Right DMA request |
| pop_l | input | 1 | Left read request |
| pop_r | input | 1 | Right read request |
| rd_data_l | output | DATA_W | Left read word |
| rd_data_r | output | DATA_W | Right read word |
| underrun_l | output | 1 | Left pop-while-empty pulse |
| underrun_r | output | 1 | Right pop-while-empty pulse |
| empty_flag | output | 2 | Empty flag per channel, bit 0 = left |
| half_flag | output | 2 | More-than-half flag per channel |
| full_flag | output | 2 | Full flag per channel |
| play_active | output | 1 | Playback-start indication |

## Verification
The assertions rely on the mode and polarity inputs being changed only between clock edges, like every other input. They also rely on reset being applied before the first sample. The stimulus changes mode, polarity and DMA selection only at the boundaries of test segments. It drives every input half a period away from the sampling edge. Within a segment, the push and pop probabilities are biased so that each channel is driven both into the full state and into the empty state.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  localparam int NUM_CH = 2;
  typedef enum logic {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } chan_e;
endpackage

// File: rtl/sfifo_channel.sv
module sfifo_channel #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] rd_data,
  output logic              underrun,
  output logic [CW-1:0]     cnt,
  output logic [CW-1:0]     cnt_nxt
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr_q, wptr_nxt, rptr_q, rptr_nxt;
  logic [CW-1:0]     cnt_q;
  logic [DATA_W-1:0] rd_q, rd_nxt;
  logic              un_q, un_nxt;
  logic              push_ok, pop_ok;

  always_comb begin
    push_ok  = push && (cnt_q != CW'(DEPTH));
    pop_ok   = pop && (cnt_q != '0);
    wptr_nxt = wptr_q;
    rptr_nxt = rptr_q;
    cnt_nxt  = cnt_q;
    rd_nxt   = rd_q;
    un_nxt   = 1'b0;
    if (push_ok) begin
      wptr_nxt = (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
    end
    if (pop_ok) begin
      rptr_nxt = (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
    end
    if (push_ok && !pop_ok) begin
      cnt_nxt = cnt_q + 1'b1;
    end else if (pop_ok && !push_ok) begin
      cnt_nxt = cnt_q - 1'b1;
    end
    if (pop) begin
      rd_nxt = pop_ok ? mem[rptr_q] : '0;
      un_nxt = !pop_ok;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) begin
      mem[wptr_q] <= push_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      rd_q   <= '0;
      un_q   <= 1'b0;
    end else begin
      wptr_q <= wptr_nxt;
      rptr_q <= rptr_nxt;
      cnt_q  <= cnt_nxt;
      if (pop) begin
        rd_q <= rd_nxt;
      end
      un_q <= un_nxt;
    end
  end

  assign cnt      = cnt_q;
  assign rd_data  = rd_q;
  assign underrun = un_q;
endmodule

// File: rtl/sfifo_dreq.sv
module sfifo_dreq #(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] cnt_nxt,
  output logic          dreq
);
  logic req_q, req_nxt;

  always_comb begin
    req_nxt = req_q;
    if (!en) begin
      req_nxt = 1'b0;
    end else if (cnt_nxt == '0) begin
      req_nxt = 1'b1;
    end else if (cnt_nxt == CW'(DEPTH)) begin
      req_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
    end else begin
      req_q <= req_nxt;
    end
  end

  assign dreq = req_q;
endmodule

// File: rtl/sfifo_steer.sv
module sfifo_steer
  import sfifo_pkg::*;
(
  input  logic              stereo,
  input  logic              dma_en,
  input  logic              ack_high,
  input  logic              host_wr,
  input  logic              host_ch,
  input  logic              dma_wr_n,
  input  logic              ack_l,
  input  logic              ack_r,
  output logic [NUM_CH-1:0] push
);
  logic host_go, dma_go, act_l, act_r, host_right;

  always_comb begin
    host_go    = !dma_en && host_wr;
    dma_go     = dma_en && !dma_wr_n;
    act_l      = ack_high ? ack_l : !ack_l;
    act_r      = stereo && (ack_high ? ack_r : !ack_r);
    host_right = stereo && (chan_e'(host_ch) == CH_RIGHT);
    push[CH_LEFT]  = (host_go && !host_right) || (dma_go && act_l);
    push[CH_RIGHT] = (host_go && host_right) || (dma_go && act_r && !act_l);
  end
endmodule

// File: rtl/stereo_sample_fifo.sv
module stereo_sample_fifo
  import sfifo_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int CAP_BITS = 1024,
  localparam int DEPTH   = CAP_BITS / DATA_W,
  localparam int CW      = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_stereo,
  input  logic              cfg_dma_en,
  input  logic              cfg_flag_low,
  input  logic              cfg_ack_high,
  input  logic              host_wr,
  input  logic              host_ch,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              dma_wr_n,
  input  logic              dma_ack_l,
  input  logic              dma_ack_r,
  output logic              dma_req_l,
  output logic              dma_req_r,
  input  logic              pop_l,
  input  logic              pop_r,
  output logic [DATA_W-1:0] rd_data_l,
  output logic [DATA_W-1:0] rd_data_r,
  output logic              underrun_l,
  output logic              underrun_r,
  output logic [1:0]        empty_flag,
  output logic [1:0]        half_flag,
  output logic [1:0]        full_flag,
  output logic              play_active
);
  logic [NUM_CH-1:0]             push, pop, under, req, req_en;
  logic [NUM_CH-1:0]             is_emp, is_mid, is_ful;
  logic [NUM_CH-1:0][CW-1:0]     cnt_q, cnt_nxt;
  logic [NUM_CH-1:0][DATA_W-1:0] rdat;
  logic                          play_q, play_nxt, all_mid, all_emp;

  assign pop    = {pop_r, pop_l};
  assign req_en = {cfg_dma_en && cfg_stereo, cfg_dma_en};

  sfifo_steer u_steer (
    .stereo   (cfg_stereo),
    .dma_en   (cfg_dma_en),
    .ack_high (cfg_ack_high),
    .host_wr  (host_wr),
    .host_ch  (host_ch),
    .dma_wr_n (dma_wr_n),
    .ack_l    (dma_ack_l),
    .ack_r    (dma_ack_r),
    .push     (push)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    sfifo_channel #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push[c]),
      .push_data (wr_data),
      .pop       (pop[c]),
      .rd_data   (rdat[c]),
      .underrun  (under[c]),
      .cnt       (cnt_q[c]),
      .cnt_nxt   (cnt_nxt[c])
    );
    sfifo_dreq #(.DEPTH(DEPTH)) u_dreq (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (req_en[c]),
      .cnt_nxt (cnt_nxt[c]),
      .dreq    (req[c])
    );
    assign is_emp[c]     = (cnt_q[c] == '0);
    assign is_mid[c]     = (cnt_q[c] > CW'(DEPTH / 2));
    assign is_ful[c]     = (cnt_q[c] == CW'(DEPTH));
    assign empty_flag[c] = is_emp[c] ^ cfg_flag_low;
    assign half_flag[c]  = is_mid[c] ^ cfg_flag_low;
    assign full_flag[c]  = is_ful[c] ^ cfg_flag_low;
  end

  always_comb begin
    all_mid  = is_mid[CH_LEFT] && (!cfg_stereo || is_mid[CH_RIGHT]);
    all_emp  = is_emp[CH_LEFT] && (!cfg_stereo || is_emp[CH_RIGHT]);
    play_nxt = play_q;
    if (all_mid) begin
      play_nxt = 1'b1;
    end else if (all_emp) begin
      play_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      play_q <= 1'b0;
    end else begin
      play_q <= play_nxt;
    end
  end

  assign play_active = play_q;
  assign dma_req_l   = req[CH_LEFT];
  assign dma_req_r   = req[CH_RIGHT];
  assign rd_data_l   = rdat[CH_LEFT];
  assign rd_data_r   = rdat[CH_RIGHT];
  assign underrun_l  = under[CH_LEFT];
  assign underrun_r  = under[CH_RIGHT];
endmodule

// File: rtl/stereo_sample_fifo_chk.sv
module stereo_sample_fifo_chk #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64,
  parameter int CW     = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_stereo,
  input logic              cfg_dma_en,
  input logic              pop_l,
  input logic [CW-1:0]     cnt_l,
  input logic [CW-1:0]     cnt_r,
  input logic              underrun_l,
  input logic              underrun_r,
  input logic [DATA_W-1:0] rd_data_l,
  input logic [DATA_W-1:0] rd_data_r,
  input logic              dma_req_l,
  input logic              dma_req_r,
  input logic              play_active
);
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_l <= CW'(DEPTH)) && (cnt_r <= CW'(DEPTH)));

  p_full_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_l == CW'(DEPTH) && !pop_l) |=> (cnt_l == CW'(DEPTH)));

  p_mono_right_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_stereo |=> (cnt_r <= $past(cnt_r)));

  p_underrun_zero_l_r7: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_l |-> (rd_data_l == '0));

  p_underrun_zero_r_r7: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_r |-> (rd_data_r == '0));

  p_play_after_mid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(play_active) |-> $past(cnt_l > CW'(DEPTH / 2)));

  p_req_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_dma_en |=> (!dma_req_l && !dma_req_r));

  p_req_when_dry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cfg_dma_en) && cnt_l == '0) |-> dma_req_l);
endmodule

bind stereo_sample_fifo stereo_sample_fifo_chk #(
  .DATA_W (DATA_W),
  .DEPTH  (DEPTH),
  .CW     (CW)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_stereo  (cfg_stereo),
  .cfg_dma_en  (cfg_dma_en),
  .pop_l       (pop_l),
  .cnt_l       (cnt_q[0]),
  .cnt_r       (cnt_q[1]),
  .underrun_l  (underrun_l),
  .underrun_r  (underrun_r),
  .rd_data_l   (rd_data_l),
  .rd_data_r   (rd_data_r),
  .dma_req_l   (dma_req_l),
  .dma_req_r   (dma_req_r),
  .play_active (play_active)
);

// File: tb/stereo_sample_fifo_test.sv
`timescale 1ns/1ps
module stereo_sample_fifo_test;
  localparam int DW = 16;
  localparam int DEP = 64;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_stereo, cfg_dma_en, cfg_flag_low, cfg_ack_high;
  logic host_wr, host_ch, dma_wr_n, dma_ack_l, dma_ack_r, pop_l, pop_r;
  logic [DW-1:0] wr_data;
  logic dma_req_l, dma_req_r, underrun_l, underrun_r, play_active;
  logic [DW-1:0] rd_data_l, rd_data_r;
  logic [1:0] empty_flag, half_flag, full_flag;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  int mq [2][DEP];
  int mh [2];
  int mt [2];
  int mc [2];
  int m_rd [2];
  bit m_un [2];
  bit m_req [2];
  bit m_play;

  always #2 clk = ~clk;

  stereo_sample_fifo uut (
    .clk(clk), .rst_n(rst_n), .cfg_stereo(cfg_stereo), .cfg_dma_en(cfg_dma_en),
    .cfg_flag_low(cfg_flag_low), .cfg_ack_high(cfg_ack_high), .host_wr(host_wr),
    .host_ch(host_ch), .wr_data(wr_data), .dma_wr_n(dma_wr_n), .dma_ack_l(dma_ack_l),
    .dma_ack_r(dma_ack_r), .dma_req_l(dma_req_l), .dma_req_r(dma_req_r),
    .pop_l(pop_l), .pop_r(pop_r), .rd_data_l(rd_data_l), .rd_data_r(rd_data_r),
    .underrun_l(underrun_l), .underrun_r(underrun_r), .empty_flag(empty_flag),
    .half_flag(half_flag), .full_flag(full_flag), .play_active(play_active)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic bit ack_on(input logic a);
    return cfg_ack_high ? (a == 1'b1) : (a == 1'b0);
  endfunction

  task automatic model_update();
    bit hg, dg, al, ar, pl, pr;
    bit push [2];
    bit popc [2];
    bit amid, aemp;
    hg = !cfg_dma_en && host_wr;
    dg = cfg_dma_en && !dma_wr_n;
    al = ack_on(dma_ack_l);
    ar = cfg_stereo && ack_on(dma_ack_r);
    push[0] = (hg && !(cfg_stereo && host_ch)) || (dg && al);
    push[1] = (hg && cfg_stereo && host_ch) || (dg && ar && !al);
    popc[0] = pop_l;
    popc[1] = pop_r;
    amid = (mc[0] > DEP/2) && (!cfg_stereo || mc[1] > DEP/2);
    aemp = (mc[0] == 0) && (!cfg_stereo || mc[1] == 0);
    if (amid) m_play = 1;
    else if (aemp) m_play = 0;
    for (int c = 0; c < 2; c++) begin
      int pre;
      pre = mc[c];
      m_un[c] = 0;
      if (popc[c]) begin
        if (pre > 0) begin
          m_rd[c] = mq[c][mh[c]];
          mh[c] = (mh[c] + 1) % DEP;
          mc[c]--;
        end else begin
          m_rd[c] = 0;
          m_un[c] = 1;
        end
      end
      if (push[c] && pre < DEP) begin
        mq[c][mt[c]] = int'(wr_data);
        mt[c] = (mt[c] + 1) % DEP;
        mc[c]++;
      end
    end
    pl = cfg_dma_en;
    pr = cfg_dma_en && cfg_stereo;
    m_req[0] = pl && (mc[0] == 0 || (m_req[0] && mc[0] != DEP));
    m_req[1] = pr && (mc[1] == 0 || (m_req[1] && mc[1] != DEP));
  endtask

  task automatic compare_all();
    for (int c = 0; c < 2; c++) begin
      chk($sformatf("R2/R5 empty flag ch%0d", c), int'(empty_flag[c]), int'((mc[c] == 0) ^ cfg_flag_low));
      chk($sformatf("R3/R5 half flag ch%0d", c), int'(half_flag[c]), int'((mc[c] > DEP/2) ^ cfg_flag_low));
      chk($sformatf("R4/R5 full flag ch%0d", c), int'(full_flag[c]), int'((mc[c] == DEP) ^ cfg_flag_low));
    end
    chk("R7 left read word", int'(rd_data_l), m_rd[0]);
    chk("R7 right read word", int'(rd_data_r), m_rd[1]);
    chk("R7 left underrun", int'(underrun_l), int'(m_un[0]));
    chk("R7 right underrun", int'(underrun_r), int'(m_un[1]));
    chk("R9 left request", int'(dma_req_l), int'(m_req[0]));
    chk("R9 right request", int'(dma_req_r), int'(m_req[1]));
    chk("R8 play active", int'(play_active), int'(m_play));
  endtask

  task automatic cycle();
    @(posedge clk);
    cyc++;
    model_update();
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle_inputs();
    host_wr = 0; host_ch = 0; dma_wr_n = 1; pop_l = 0; pop_r = 0;
    dma_ack_l = cfg_ack_high ? 1'b0 : 1'b1;
    dma_ack_r = cfg_ack_high ? 1'b0 : 1'b1;
  endtask

  task automatic drain_all();
    idle_inputs();
    pop_l = 1; pop_r = 1;
    for (int i = 0; i < DEP + 1; i++) cycle();
    idle_inputs();
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      if (cyc > 150000 && !done) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int r;
    r = $urandom(32'h5eed_0042);
    rst_n = 0;
    cfg_stereo = 0; cfg_dma_en = 0; cfg_flag_low = 0; cfg_ack_high = 0;
    wr_data = '0;
    idle_inputs();
    for (int c = 0; c < 2; c++) begin
      mh[c] = 0; mt[c] = 0; mc[c] = 0; m_rd[c] = 0; m_un[c] = 0; m_req[c] = 0;
    end
    m_play = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    compare_all();

    // R1 R3 R4: mono fill through host, with ch select high to show it is ignored
    host_wr = 1; host_ch = 1;
    for (int i = 0; i < DEP + 1; i++) begin
      wr_data = DW'(16'h100 + i);
      cycle();
      if (i == DEP/2 - 1) chk("R3 half flag at exactly half", int'(half_flag[0]), 0);
      if (i == DEP/2) chk("R3 half flag above half", int'(half_flag[0]), 1);
      if (i == DEP - 2) chk("R1 not full one word short", int'(full_flag[0]), 0);
      if (i == DEP - 1) chk("R1 full after DEPTH writes", int'(full_flag[0]), 1);
    end
    chk("R6 mono ignores host_ch: right stays empty", int'(empty_flag[1]), 1);
    chk("R8 playback started in mono", int'(play_active), 1);
    idle_inputs();
    pop_l = 1;
    cycle();
    chk("R4 oldest word kept, overflow word dropped", int'(rd_data_l), 16'h100);
    // R5 polarity flip
    idle_inputs();
    cfg_flag_low = 1;
    cycle();
    chk("R5 inverted empty flag when holding words", int'(empty_flag[0]), 1);
    drain_all();
    chk("R7 underrun after draining", int'(underrun_l), 1);
    chk("R7 underrun read word is zero", int'(rd_data_l), 0);
    cfg_flag_low = 0;

    // R6 stereo routing
    cfg_stereo = 1;
    idle_inputs();
    host_wr = 1; host_ch = 1; wr_data = 16'hBEEF;
    cycle();
    host_ch = 0; wr_data = 16'hCAFE;
    cycle();
    idle_inputs();
    pop_l = 1; pop_r = 1;
    cycle();
    chk("R6 right channel got host_ch=1 word", int'(rd_data_r), 16'hBEEF);
    chk("R6 left channel got host_ch=0 word", int'(rd_data_l), 16'hCAFE);
    idle_inputs();

    // R10 R11 DMA path, active-high ack, host ignored
    cfg_dma_en = 1; cfg_ack_high = 1;
    idle_inputs();
    cycle();
    chk("R9 right request while dry in stereo", int'(dma_req_r), 1);
    host_wr = 1; host_ch = 0; wr_data = 16'h1111;
    cycle();
    chk("R11 host write ignored under DMA", int'(empty_flag[0]), 1);
    host_wr = 0;
    dma_ack_r = 1; dma_wr_n = 0; wr_data = 16'h2222;
    cycle();
    dma_ack_l = 1; dma_ack_r = 1; wr_data = 16'h3333;
    cycle();
    idle_inputs();
    pop_l = 1; pop_r = 1;
    cycle();
    chk("R10 right ack steers DMA write", int'(rd_data_r), 16'h2222);
    chk("R10 both acks: left wins", int'(rd_data_l), 16'h3333);
    idle_inputs();
    cfg_dma_en = 0;
    dma_wr_n = 0; dma_ack_l = 1;
    cycle();
    chk("R11 DMA strobe ignored without DMA", int'(empty_flag[0]), 1);
    idle_inputs();
    cycle();

    // Random segments
    for (int seg = 0; seg < 24; seg++) begin
      int pw, pp;
      idle_inputs();
      cfg_stereo = 1'($urandom_range(0, 1));
      cfg_dma_en = 1'($urandom_range(0, 1));
      cfg_flag_low = 1'($urandom_range(0, 1));
      cfg_ack_high = 1'($urandom_range(0, 1));
      pw = (seg % 2 == 0) ? 80 : 25;
      pp = (seg % 2 == 0) ? 20 : 75;
      for (int i = 0; i < 300; i++) begin
        bit w;
        w = ($urandom_range(0, 99) < pw);
        wr_data = DW'($urandom());
        host_wr = w;
        host_ch = 1'($urandom_range(0, 1));
        dma_wr_n = !(w || ($urandom_range(0, 9) == 0));
        dma_ack_l = 1'($urandom_range(0, 1));
        dma_ack_r = 1'($urandom_range(0, 1));
        pop_l = ($urandom_range(0, 99) < pp);
        pop_r = ($urandom_range(0, 99) < pp);
        cycle();
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule